// File: doc/BRIEF.md
# Programmable Video Blanking Generator

This block drives a single BLANK output for interlaced NTSC or PAL video. It runs on the pixel-rate clock. It takes a one-cycle strobe at the leading edge of each HSYNC, the current line number from an external line counter, a field flag (odd or even) and a standard flag (NTSC or PAL). An internal horizontal counter returns to zero on every strobe. Host-written registers then set the pixel counts where horizontal blanking begins and ends, and the lines where vertical blanking begins and ends. BLANK is the OR of the horizontal and vertical blanking states.

Both horizontal edges fall on even pixel counts only. The blanking-start value is ten bits wide and is written as a low byte and a separate two-bit high part. The vertical line values are nine bits wide. The line they select depends on the field and on the standard held for the current field. Register writes go to a staging copy. That copy is taken over only at a line boundary, so no line is ever partly blanked under old values and partly under new ones.

Top module: `vbg_top`

## Requirements
- R1: From reset until the first HSYNC strobe has been seen, `blank` is 1. After reset the registers hold these defaults: horizontal start 720, horizontal end 122, vertical start 257, vertical end 15.
- R2: On the clock edge where `hsync_stb` is 1, the horizontal count goes to 0. After that it advances by one per clock and saturates at 1023. Horizontal blanking becomes active in the cycle after the one in which the count equals the horizontal start value. That value is the high part (bits 1:0 at address 0x11) joined above the low byte (address 0x10).
- R3: Bit 0 of the horizontal start value is ignored (treated as 0), so horizontal blanking only starts on even counts.
- R4: Horizontal blanking becomes inactive in the cycle after the count equals the horizontal end byte (address 0x12) with its bit 0 cleared. When the start and end values are equal, start wins.
- R5: In an odd field (`field_even`=0), vertical blanking becomes active after a strobe whose `line_num` equals n+5. Here n is the 9-bit vertical start: bit 0 of address 0x14 above the byte at 0x13. This holds for both standards.
- R6: In an even field, vertical blanking starts on line n+268 in NTSC (`mode_pal`=0) and on line n+318 in PAL (`mode_pal`=1).
- R7: Vertical blanking stays active until a strobe whose `line_num` equals m plus the same field and standard offset. Here m is the 9-bit vertical end: bit 0 of 0x16 above the byte at 0x15. If both lines match, start wins. Between strobes the vertical state does not change.
- R8: `field_even` and `mode_pal` are taken only at a field start. A field start is a strobe on which `field_even` differs from the held field, or the first strobe after reset. A change of `mode_pal` in mid-field has no effect until the next field start.
- R9: A write (`wr_en`=1) to 0x10–0x16 changes nothing until the next strobe. At that strobe it takes effect for the line the strobe begins. Writes to any other address are ignored.
- R10: `blank` equals the OR of the horizontal and vertical blanking states, once the first strobe has been seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hsync_stb | input | 1 | One-cycle strobe at HSYNC leading edge |
| line_num | input | 10 | Line number of the line starting at the strobe |
| field_even | input | 1 | 1 = even field, 0 = odd field |
| mode_pal | input | 1 | 1 = PAL, 0 = NTSC |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register sub-address |
| wr_data | input | 8 | Register write data |
| blank | output | 1 | Combined blanking output |

## Verification
A wrong horizontal count or a wrong start/end compare shows up at `blank` within one line. The edge moves by a pixel or more, or it never toggles at all. A wrong latched field or standard only becomes visible when a strobe reaches the target line, so vertical errors can stay hidden for a whole field. For that reason the bench drives `line_num` directly onto and around each target line. A staging copy that is taken over too early shows up as a mid-line change in `blank`, in the same cycle the write lands.

// File: rtl/vbg_pkg.sv
package vbg_pkg;
  localparam int HCW = 10;
  localparam int HEW = 8;
  localparam int VW  = 9;
  localparam int LW  = 10;

  localparam logic [7:0] A_HS_LO = 8'h10;
  localparam logic [7:0] A_HS_HI = 8'h11;
  localparam logic [7:0] A_HE    = 8'h12;
  localparam logic [7:0] A_VS_LO = 8'h13;
  localparam logic [7:0] A_VS_HI = 8'h14;
  localparam logic [7:0] A_VE_LO = 8'h15;
  localparam logic [7:0] A_VE_HI = 8'h16;

  localparam logic [HCW-1:0] DEF_HS = 10'd720;
  localparam logic [HEW-1:0] DEF_HE = 8'd122;
  localparam logic [VW-1:0]  DEF_VS = 9'd257;
  localparam logic [VW-1:0]  DEF_VE = 9'd15;

  localparam int OFF_ODD       = 5;
  localparam int OFF_EVEN_NTSC = 268;
  localparam int OFF_EVEN_PAL  = 318;

  function automatic logic [LW-1:0] line_target(input logic [VW-1:0] n,
                                                input logic even, input logic pal);
    logic [LW-1:0] off;
    off = !even ? LW'(OFF_ODD) : (pal ? LW'(OFF_EVEN_PAL) : LW'(OFF_EVEN_NTSC));
    return LW'(n) + off;
  endfunction

  function automatic logic [HCW-1:0] even_pos(input logic [HCW-1:0] v);
    return {v[HCW-1:1], 1'b0};
  endfunction
endpackage

// File: rtl/vbg_regs.sv
module vbg_regs
  import vbg_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [7:0]     wr_addr,
  input  logic [7:0]     wr_data,
  input  logic           line_stb,
  output logic [HCW-1:0] act_hs,
  output logic [HEW-1:0] act_he,
  output logic [VW-1:0]  stg_vs,
  output logic [VW-1:0]  stg_ve
);
  logic [7:0] hs_lo, he_q, vs_lo, ve_lo;
  logic [1:0] hs_hi;
  logic       vs_hi, ve_hi;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_lo <= DEF_HS[7:0];
      hs_hi <= DEF_HS[9:8];
      he_q  <= DEF_HE;
      vs_lo <= DEF_VS[7:0];
      vs_hi <= DEF_VS[8];
      ve_lo <= DEF_VE[7:0];
      ve_hi <= DEF_VE[8];
    end else if (wr_en) begin
      case (wr_addr)
        A_HS_LO: hs_lo <= wr_data;
        A_HS_HI: hs_hi <= wr_data[1:0];
        A_HE:    he_q  <= wr_data;
        A_VS_LO: vs_lo <= wr_data;
        A_VS_HI: vs_hi <= wr_data[0];
        A_VE_LO: ve_lo <= wr_data;
        A_VE_HI: ve_hi <= wr_data[0];
        default: ;
      endcase
    end
  end

  assign stg_vs = {vs_hi, vs_lo};
  assign stg_ve = {ve_hi, ve_lo};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_hs <= even_pos(DEF_HS);
      act_he <= {DEF_HE[HEW-1:1], 1'b0};
    end else if (line_stb) begin
      act_hs <= even_pos({hs_hi, hs_lo});
      act_he <= {he_q[HEW-1:1], 1'b0};
    end
  end

  AST_ACT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !line_stb |=> $stable(act_hs) && $stable(act_he)); // R9
  AST_HS_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    line_stb |=> !act_hs[0] && !act_he[0]); // R3
endmodule

// File: rtl/vbg_hgen.sv
module vbg_hgen
  import vbg_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           line_stb,
  input  logic           seen,
  input  logic [HCW-1:0] act_hs,
  input  logic [HEW-1:0] act_he,
  output logic           hblank
);
  localparam logic [HCW-1:0] HMAX = '1;
  logic [HCW-1:0] hcnt;
  logic           hit_start, hit_end;

  assign hit_start = seen && (hcnt == act_hs);
  assign hit_end   = seen && (hcnt == {{(HCW-HEW){1'b0}}, act_he});

  always_ff @(posedge clk) begin
    if (!rst_n)            hcnt <= '0;
    else if (line_stb)     hcnt <= '0;
    else if (!seen)        hcnt <= '0;
    else if (hcnt != HMAX) hcnt <= hcnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         hblank <= 1'b0;
    else if (hit_start) hblank <= 1'b1;
    else if (hit_end)   hblank <= 1'b0;
  end

  AST_HCNT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    line_stb |=> hcnt == '0); // R2
  AST_HB_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    hit_start |=> hblank); // R2
  AST_HB_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    hit_end && !hit_start |=> !hblank); // R4
  AST_HCNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    !line_stb && hcnt == HMAX |=> hcnt == HMAX); // R2
endmodule

// File: rtl/vbg_vgen.sv
module vbg_vgen
  import vbg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_stb,
  input  logic [LW-1:0] line_num,
  input  logic          field_even,
  input  logic          mode_pal,
  input  logic [VW-1:0] stg_vs,
  input  logic [VW-1:0] stg_ve,
  output logic          vblank
);
  logic fld_q, pal_q, fvalid;
  logic field_start, nxt_fld, nxt_pal;
  logic [LW-1:0] vs_line, ve_line;
  logic hit_vs, hit_ve;

  assign field_start = !fvalid || (field_even != fld_q);
  assign nxt_fld     = field_start ? field_even : fld_q;
  assign nxt_pal     = field_start ? mode_pal   : pal_q;
  assign vs_line     = line_target(stg_vs, nxt_fld, nxt_pal);
  assign ve_line     = line_target(stg_ve, nxt_fld, nxt_pal);
  assign hit_vs      = line_stb && (line_num == vs_line);
  assign hit_ve      = line_stb && (line_num == ve_line);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fld_q  <= 1'b0;
      pal_q  <= 1'b0;
      fvalid <= 1'b0;
    end else if (line_stb) begin
      fld_q  <= nxt_fld;
      pal_q  <= nxt_pal;
      fvalid <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      vblank <= 1'b0;
    else if (hit_vs) vblank <= 1'b1;
    else if (hit_ve) vblank <= 1'b0;
  end

  AST_VB_SET: assert property (@(posedge clk) disable iff (!rst_n)
    hit_vs |=> vblank); // R5
  AST_VB_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    hit_ve && !hit_vs |=> !vblank); // R7
  AST_VB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !line_stb |=> $stable(vblank)); // R7
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    line_stb && fvalid && field_even == fld_q |=> $stable(pal_q)); // R8
endmodule

// File: rtl/vbg_top.sv
module vbg_top
  import vbg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hsync_stb,
  input  logic [LW-1:0] line_num,
  input  logic          field_even,
  input  logic          mode_pal,
  input  logic          wr_en,
  input  logic [7:0]    wr_addr,
  input  logic [7:0]    wr_data,
  output logic          blank
);
  logic           seen_q, hblank, vblank;
  logic [HCW-1:0] act_hs;
  logic [HEW-1:0] act_he;
  logic [VW-1:0]  stg_vs, stg_ve;

  always_ff @(posedge clk) begin
    if (!rst_n)         seen_q <= 1'b0;
    else if (hsync_stb) seen_q <= 1'b1;
  end

  vbg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .line_stb(hsync_stb), .act_hs(act_hs), .act_he(act_he),
    .stg_vs(stg_vs), .stg_ve(stg_ve)
  );

  vbg_hgen u_hgen (
    .clk(clk), .rst_n(rst_n), .line_stb(hsync_stb), .seen(seen_q),
    .act_hs(act_hs), .act_he(act_he), .hblank(hblank)
  );

  vbg_vgen u_vgen (
    .clk(clk), .rst_n(rst_n), .line_stb(hsync_stb), .line_num(line_num),
    .field_even(field_even), .mode_pal(mode_pal),
    .stg_vs(stg_vs), .stg_ve(stg_ve), .vblank(vblank)
  );

  assign blank = !seen_q || hblank || vblank;

  AST_BLANK_PRE: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_q |-> blank); // R1
  AST_BLANK_OR: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q && !hblank && !vblank |-> !blank); // R10
endmodule

// File: tb/vbg_top_test.sv
module vbg_top_test;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       hsync_stb = 0;
  logic [9:0] line_num = 0;
  logic       field_even = 0;
  logic       mode_pal = 0;
  logic       wr_en = 0;
  logic [7:0] wr_addr = 0;
  logic [7:0] wr_data = 0;
  logic       blank;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  vbg_top uut (
    .clk(clk), .rst_n(rst_n), .hsync_stb(hsync_stb), .line_num(line_num),
    .field_even(field_even), .mode_pal(mode_pal), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .blank(blank)
  );

  // bench model, written from the requirements
  logic [9:0] m_hc, m_ahs, m_ahe;
  logic [7:0] s_hslo, s_he, s_vslo, s_velo;
  logic [1:0] s_hshi;
  logic       s_vshi, s_vehi;
  bit m_hb, m_vb, m_seen, m_fv, m_fld, m_pal;

  function automatic int offset_for(bit even, bit pal);
    if (!even) return 5;
    return pal ? 318 : 268;
  endfunction

  function automatic bit exp_blank();
    return !m_seen || m_hb || m_vb;
  endfunction

  task automatic model_reset();
    m_hc = 0; m_hb = 0; m_vb = 0; m_seen = 0; m_fv = 0; m_fld = 0; m_pal = 0;
    s_hslo = 8'hD0; s_hshi = 2'd2; s_he = 8'd122;
    s_vslo = 8'd1; s_vshi = 1'b1; s_velo = 8'd15; s_vehi = 1'b0;
    m_ahs = 10'd720; m_ahe = 10'd122;
  endtask

  task automatic model_update();
    bit nf, np;
    int n, m, ts, te;
    if (m_seen) begin
      if (m_hc == m_ahs) m_hb = 1;
      else if (m_hc == m_ahe) m_hb = 0;
    end
    if (hsync_stb) begin
      nf = (!m_fv || field_even != m_fld) ? field_even : m_fld;
      np = (!m_fv || field_even != m_fld) ? mode_pal : m_pal;
      n = {s_vshi, s_vslo};
      m = {s_vehi, s_velo};
      ts = n + offset_for(nf, np);
      te = m + offset_for(nf, np);
      if (int'(line_num) == ts) m_vb = 1;
      else if (int'(line_num) == te) m_vb = 0;
      m_fld = nf; m_pal = np; m_fv = 1;
      m_ahs = {s_hshi, s_hslo} & 10'h3FE;
      m_ahe = {2'b00, s_he} & 10'h3FE;
      m_hc = 0;
    end else if (m_seen) begin
      if (m_hc != 10'h3FF) m_hc = m_hc + 1;
    end
    if (hsync_stb) m_seen = 1;
    if (wr_en) begin
      case (wr_addr)
        8'h10: s_hslo = wr_data;
        8'h11: s_hshi = wr_data[1:0];
        8'h12: s_he = wr_data;
        8'h13: s_vslo = wr_data;
        8'h14: s_vshi = wr_data[0];
        8'h15: s_velo = wr_data;
        8'h16: s_vehi = wr_data[0];
        default: ;
      endcase
    end
  endtask

  task automatic check(input string tag, input bit expv);
    checks++;
    if (blank !== expv) begin
      fails++;
      $display("FAIL %s: blank=%b expected %b at %0t", tag, blank, expv, $time);
    end
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    model_update();
    @(negedge clk);
    check(tag, exp_blank());
  endtask

  task automatic do_line(input string tag, input int ln, input int len);
    hsync_stb = 1; line_num = 10'(ln);
    step(tag);
    hsync_stb = 0;
    repeat (len - 1) step(tag);
  endtask

  task automatic wr(input string tag, input logic [7:0] a, input logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    step(tag);
    wr_en = 0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    check("R1 reset", 1'b1);
    rst_n = 1;
    repeat (5) step("R1 before first strobe");
    check("R1 still high before strobe", 1'b1);

    // defaults: odd NTSC, line 100 is outside vertical blanking, line short
    do_line("R1 defaults", 100, 60);
    check("R1 default line unblanked", 1'b0);
    do_line("R1 defaults", 262, 30);
    check("R1 default vstart 257+5", 1'b1);
    do_line("R1 defaults", 20, 30);
    check("R1 default vend 15+5", 1'b0);

    // horizontal: odd start value 21 behaves as 20, end 33 as 32
    wr("R9 staged", 8'h10, 8'd21);
    wr("R9 staged", 8'h11, 8'd0);
    wr("R9 staged", 8'h12, 8'd33);
    check("R9 no effect before strobe", 1'b0);
    do_line("R3", 101, 60);
    do_line("R2", 102, 60);
    // explicit edge probe: at count 21 blank high, count 33 low
    hsync_stb = 1; line_num = 10'd103; step("R2");
    hsync_stb = 0;
    repeat (20) step("R2");
    check("R3 blank at count 20 not yet visible", 1'b0);
    step("R2");
    check("R2 blank rises after count 20", 1'b1);
    repeat (12) step("R4");
    check("R4 blank falls after count 32", 1'b0);
    repeat (10) step("R4");

    // start wins on tie
    wr("R4 tie", 8'h12, 8'd40);
    wr("R4 tie", 8'h10, 8'd40);
    do_line("R4 tie", 104, 70);
    do_line("R4 tie", 105, 70);
    check("R4 tie keeps blank", 1'b1);

    // wrapping horizontal window, high part used, saturation
    wr("R2 high part", 8'h11, 8'd1);
    wr("R2 high part", 8'h10, 8'd4);
    wr("R2 high part", 8'h12, 8'd10);
    do_line("R2 high part", 106, 200);
    do_line("R2 saturate", 107, 1200);
    do_line("R2 wrap", 108, 300);

    // invalid address ignored
    wr("R9 bad addr", 8'h17, 8'h00);
    wr("R9 bad addr", 8'h0F, 8'h00);
    do_line("R9 bad addr", 109, 300);

    // vertical, odd field
    wr("R5", 8'h10, 8'hFE); wr("R5", 8'h11, 8'd3); wr("R5", 8'h12, 8'd0);
    wr("R5", 8'h13, 8'd10); wr("R5", 8'h14, 8'd0);
    wr("R7", 8'h15, 8'd30); wr("R7", 8'h16, 8'd0);
    do_line("R5", 14, 40);
    check("R5 line 14 not blanked", 1'b0);
    do_line("R5", 15, 40);
    check("R5 line n+5 blanked", 1'b1);
    do_line("R7", 20, 40);
    check("R7 held", 1'b1);
    do_line("R7", 35, 40);
    check("R7 end m+5", 1'b0);

    // even field NTSC
    field_even = 1;
    do_line("R6", 277, 40);
    check("R6 ntsc n+268-1 clear", 1'b0);
    do_line("R6", 278, 40);
    check("R6 ntsc n+268 blanked", 1'b1);
    mode_pal = 1;
    do_line("R8", 328, 40);
    do_line("R8", 298, 40);
    check("R8 mode held mid-field", 1'b0);
    do_line("R8", 328, 40);
    check("R8 pal offset not yet used", 1'b0);
    field_even = 0;
    do_line("R8", 1, 40);
    field_even = 1;
    do_line("R6", 328, 40);
    check("R6 pal n+318 blanked", 1'b1);
    do_line("R7", 348, 40);
    check("R7 pal end m+318", 1'b0);

    // constrained random mix
    for (int i = 0; i < 300; i++) begin
      int r;
      r = $urandom_range(0, 9);
      if (r < 4) begin
        logic [7:0] a;
        a = 8'h10 + 8'($urandom_range(0, 7));
        wr("R10 random", a, 8'($urandom_range(0, 255)));
      end
      if ($urandom_range(0, 15) == 0) field_even = ~field_even;
      if ($urandom_range(0, 7) == 0) mode_pal = ~mode_pal;
      begin
        int base, ln;
        base = {s_vshi, s_vslo} + offset_for(field_even, mode_pal);
        if ($urandom_range(0, 1) == 1)
          base = {s_vehi, s_velo} + offset_for(field_even, mode_pal);
        ln = base + int'($urandom_range(0, 2)) - 1;
        if (ln < 0) ln = 0;
        do_line("R10 random", ln % 1024, int'($urandom_range(20, 300)));
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule